// File: doc/BRIEF.md
# Multi-Channel DMA Bus Arbiter

This block decides, one transfer unit at a time, which of several DMA channels or a single external bus master owns the shared bus. Each channel presents a request, a mode bit (burst or cycle-steal), a flag marking the request as coming from a peripheral, and a done flag for the final unit of its block. A common unit-done strobe marks the end of every channel-driven transfer unit. Grants are registered and change only at those boundaries, or when the external master releases the bus.

Channel priority is fixed: a lower channel number always ranks higher. A burst channel that wins keeps the bus unit after unit. A higher burst channel preempts a lower one at the next boundary, and the lower channel resumes once the higher one has finished. A cycle-steal channel that wins takes one unit. After that unit the bus goes to the best pending burst channel if there is one, which gives a strict high, low, high, low interleave without handing the bus out. If no burst is pending, the bus goes to the external master if it is asking. The external master never receives the bus while any burst request is still live.

Requests sourced by a peripheral are always treated as cycle-steal. Only the lowest `PERIPH_CH` channels accept a peripheral as a source. Address generation, data movement and the legality of source and destination belong to the surrounding DMA engine.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst` is high at a rising clock edge, all of `ch_gnt` and `ext_gnt` are 0 after that edge.
- R2: At a decision point, the lowest-numbered qualified requesting channel wins, unless R5 or R7 apply. Here, "burst" means `ch_burst[i]`=1 and `ch_periph[i]`=0.
- R3: A channel grant is held unchanged until a clock edge with `unit_done`=1. An external grant is held for as long as `ext_req` stays 1. When nothing is granted, every edge is a decision point.
- R4: A higher burst channel that requests during a lower burst channel's transfer takes the bus at the next unit boundary. The lower channel is granted again once the higher one stops requesting or signals done.
- R5: When the top requester is a cycle-steal channel and a burst channel is pending, grants alternate between the cycle-steal channel and the highest pending burst channel, one unit each. `ext_gnt` stays 0 throughout.
- R6: `ext_gnt` is never granted at a decision in which any qualified burst request is pending.
- R7: After a cycle-steal unit with no burst pending, the bus passes to the external master if `ext_req`=1. When the external master releases the bus, the cycle-steal channel is granted again.
- R8: At most one of `ch_gnt` bits and `ext_gnt` is 1 at any time; bit i of `ch_gnt` grants channel i.
- R9: A request with `ch_periph[i]`=1 is handled as cycle-steal regardless of `ch_burst[i]`.
- R10: A channel with index at or above `PERIPH_CH` (default 6) ignores a request while `ch_periph[i]`=1.
- R11: A granted channel with `ch_done[i]`=1 at its unit boundary is not granted at that boundary. A channel whose request is low at a boundary is dropped there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NUM_CH | Per-channel transfer request |
| ch_burst | input | NUM_CH | Per-channel mode: 1 burst, 0 cycle-steal |
| ch_periph | input | NUM_CH | Request is sourced by a peripheral |
| ch_done | input | NUM_CH | Current unit is the channel's last one |
| unit_done | input | 1 | The granted channel's transfer unit ends this cycle |
| ext_req | input | 1 | External bus master asks for the bus |
| ch_gnt | output | NUM_CH | One-hot channel grant |
| ext_gnt | output | 1 | External master grant |

## Verification
Two functions can land on the same boundary: the interleave of a cycle-steal channel with a lower burst channel, and the hand-back of the bus to a waiting external master. The bench holds `ext_req` high through a whole cycle-steal and burst interleave. It then checks that every boundary alternates the two channels and that `ext_gnt` stays 0. Once the burst request drops, it checks that the same boundary hands the bus to the external master. A second collision, a channel signalling done while its request is still high, is judged by the next grant going to the waiting lower channel.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_CH   = 2'd1,
        DEC_EXT  = 2'd2,
        DEC_IDLE = 2'd3
    } arb_dec_e;
endpackage

// File: rtl/dma_req_qualify.sv
module dma_req_qualify #(
    parameter int NUM_CH    = 8,
    parameter int PERIPH_CH = 6
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] burst_i,
    input  logic [NUM_CH-1:0] periph_i,
    output logic [NUM_CH-1:0] eff_req_o,
    output logic [NUM_CH-1:0] eff_burst_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i < PERIPH_CH) begin : g_periph_ok
            assign eff_req_o[i] = req_i[i];
        end else begin : g_periph_blocked
            assign eff_req_o[i] = req_i[i] & ~periph_i[i];
        end
        assign eff_burst_o[i] = burst_i[i] & ~periph_i[i];
    end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] onehot_o,
    output logic         any_o
);
    always_comb begin
        onehot_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i] && (onehot_o == '0)) begin
                onehot_o[i] = 1'b1;
            end
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int PERIPH_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_burst,
    input  logic [NUM_CH-1:0] ch_periph,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic              unit_done,
    input  logic              ext_req,
    output logic [NUM_CH-1:0] ch_gnt,
    output logic              ext_gnt
);
    typedef struct packed {
        logic [NUM_CH-1:0] gnt;
        logic              ext;
        logic              last_cs;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_CH-1:0] eff_req, eff_burst;
    logic [NUM_CH-1:0] avail, burst_vec;
    logic [NUM_CH-1:0] top_oh, topb_oh;
    logic              top_any, topb_any;
    logic              boundary;
    logic              top_is_burst;
    arb_dec_e          dec;
    logic [NUM_CH-1:0] pick_d;
    logic              cs_d;

    dma_req_qualify #(.NUM_CH(NUM_CH), .PERIPH_CH(PERIPH_CH)) u_qual (
        .req_i      (ch_req),
        .burst_i    (ch_burst),
        .periph_i   (ch_periph),
        .eff_req_o  (eff_req),
        .eff_burst_o(eff_burst)
    );

    // A channel finishing its block on this boundary is out of the running.
    assign avail     = eff_req & ~(st_q.gnt & ch_done & {NUM_CH{unit_done}});
    assign burst_vec = avail & eff_burst;

    dma_prio_pick #(.W(NUM_CH)) u_pick_all (
        .vec_i   (avail),
        .onehot_o(top_oh),
        .any_o   (top_any)
    );

    dma_prio_pick #(.W(NUM_CH)) u_pick_burst (
        .vec_i   (burst_vec),
        .onehot_o(topb_oh),
        .any_o   (topb_any)
    );

    assign top_is_burst = |(top_oh & eff_burst);

    always_comb begin
        if (st_q.ext)           boundary = ~ext_req;
        else if (|st_q.gnt)     boundary = unit_done;
        else                    boundary = 1'b1;
    end

    always_comb begin
        dec    = DEC_HOLD;
        pick_d = '0;
        cs_d   = st_q.last_cs;
        if (boundary) begin
            if (top_any) begin
                if (top_is_burst) begin
                    dec    = DEC_CH;
                    pick_d = top_oh;
                    cs_d   = 1'b0;
                end else if (st_q.last_cs && topb_any) begin
                    dec    = DEC_CH;
                    pick_d = topb_oh;
                    cs_d   = 1'b0;
                end else if (st_q.last_cs && ext_req) begin
                    dec    = DEC_EXT;
                    cs_d   = 1'b0;
                end else begin
                    dec    = DEC_CH;
                    pick_d = top_oh;
                    cs_d   = 1'b1;
                end
            end else if (ext_req) begin
                dec  = DEC_EXT;
                cs_d = 1'b0;
            end else begin
                dec  = DEC_IDLE;
                cs_d = 1'b0;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (dec)
            DEC_CH: begin
                st_d.gnt = pick_d;
                st_d.ext = 1'b0;
            end
            DEC_EXT: begin
                st_d.gnt = '0;
                st_d.ext = 1'b1;
            end
            DEC_IDLE: begin
                st_d.gnt = '0;
                st_d.ext = 1'b0;
            end
            default: ;
        endcase
        st_d.last_cs = cs_d;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ch_gnt  = st_q.gnt;
    assign ext_gnt = st_q.ext;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH    = 8,
    parameter int PERIPH_CH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_burst,
    input logic [NUM_CH-1:0] ch_periph,
    input logic [NUM_CH-1:0] ch_done,
    input logic              unit_done,
    input logic              ext_req,
    input logic [NUM_CH-1:0] ch_gnt,
    input logic              ext_gnt
);
    localparam logic [NUM_CH-1:0] HIGH_MASK = ~((NUM_CH'(1) << PERIPH_CH) - NUM_CH'(1));

    logic [NUM_CH-1:0] burst_live;
    assign burst_live = ch_req & ch_burst & ~ch_periph & ~(ch_gnt & ch_done & {NUM_CH{unit_done}});

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ch_gnt == '0) && !ext_gnt); // R1

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst) $onehot0({ch_gnt, ext_gnt})); // R8

    AST_CH_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((|ch_gnt) && !unit_done) |=> (ch_gnt == $past(ch_gnt))); // R3

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_gnt && ext_req) |=> ext_gnt); // R3

    AST_EXT_AFTER_BURSTS: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_gnt) |-> ($past(burst_live) == '0)); // R6

    AST_HIGH_NO_PERIPH: assert property (@(posedge clk) disable iff (rst)
        ((ch_gnt & ~$past(ch_gnt) & $past(ch_periph) & HIGH_MASK) == '0)); // R10
endmodule

bind dma_bus_arbiter dma_arb_checker #(.NUM_CH(NUM_CH), .PERIPH_CH(PERIPH_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ch_req   (ch_req),
    .ch_burst (ch_burst),
    .ch_periph(ch_periph),
    .ch_done  (ch_done),
    .unit_done(unit_done),
    .ext_req  (ext_req),
    .ch_gnt   (ch_gnt),
    .ext_gnt  (ext_gnt)
);

// File: tb/sim_dma_bus_arbiter.sv
`timescale 1ns/1ps
module sim_dma_bus_arbiter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] ch_req = '0, ch_burst = '0, ch_periph = '0, ch_done = '0;
    logic         unit_done = 1'b0, ext_req = 1'b0;
    logic [N-1:0] ch_gnt;
    logic         ext_gnt;

    int checks = 0, fails = 0;
    logic [N:0] exp_q[$];
    string      tag_q[$];
    bit         finished = 0;

    always #5 clk = ~clk;

    dma_bus_arbiter #(.NUM_CH(N), .PERIPH_CH(6)) u0 (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_burst(ch_burst),
        .ch_periph(ch_periph), .ch_done(ch_done), .unit_done(unit_done),
        .ext_req(ext_req), .ch_gnt(ch_gnt), .ext_gnt(ext_gnt)
    );

    // Monitor: compare every posted expectation shortly after the edge it belongs to.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [N:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({ch_gnt, ext_gnt} !== e) begin
                fails++;
                $display("FAIL %s: got ch_gnt=%b ext=%b expected ch_gnt=%b ext=%b",
                         t, ch_gnt, ext_gnt, e[N:1], e[0]);
            end
        end
    end

    // Driver: inputs already set at the falling edge; post expectation, clock one edge.
    task automatic step(input logic ud, input int ch, input logic ext, input string tag);
        logic [N-1:0] g;
        @(negedge clk);
        unit_done = ud;
        g = (ch < 0) ? '0 : (N'(1) << ch);
        exp_q.push_back({g, ext});
        tag_q.push_back(tag);
        @(posedge clk);
        #3;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        ch_req = '0;
        step(1, -1, 0, "R1 reset idle");
        step(0, -1, 0, "R1 reset held");
        @(negedge clk); rst = 1'b0;

        // Bursts on 3 and 5
        ch_req[3] = 1; ch_burst[3] = 1; ch_req[5] = 1; ch_burst[5] = 1;
        step(0, 3, 0, "R2 lowest burst wins");
        ch_req[1] = 1; ch_burst[1] = 1;
        step(0, 3, 0, "R3 hold without unit_done");
        step(1, 1, 0, "R4 higher burst preempts");
        step(1, 1, 0, "R4 higher burst keeps bus");
        ch_done[1] = 1;
        step(1, 3, 0, "R11 done channel not regranted");
        ch_done[1] = 0; ch_req[1] = 0;
        step(1, 3, 0, "R4 lower burst resumes");
        ch_req[3] = 0; ext_req = 1;
        step(1, 5, 0, "R11 dropped request, R6 ext waits");
        step(1, 5, 0, "R6 ext waits for burst");
        ch_req[5] = 0;
        step(1, -1, 1, "R6 ext after bursts end");
        ch_req[2] = 1; ch_burst[2] = 0;
        step(1, -1, 1, "R3 ext held while requesting");
        ext_req = 0;
        step(0, 2, 0, "R3 ext release, cycle-steal granted");
        ext_req = 1;
        step(1, -1, 1, "R7 cycle-steal yields to ext");
        ext_req = 0;
        step(0, 2, 0, "R7 cycle-steal back after ext");

        // Interleave with ext waiting
        ch_req[4] = 1; ch_burst[4] = 1; ext_req = 1;
        step(1, 4, 0, "R5 interleave low burst");
        step(1, 2, 0, "R5 interleave high cs");
        step(1, 4, 0, "R5 interleave low burst again");
        step(1, 2, 0, "R5 interleave high cs again");
        ch_req[4] = 0;
        step(1, -1, 1, "R7 ext once burst gone");
        ch_req[2] = 0; ext_req = 0;
        step(0, -1, 0, "R3 ext release to idle");

        // Peripheral source forces cycle-steal
        ch_req[1] = 1; ch_burst[1] = 1; ch_periph[1] = 1;
        ch_req[4] = 1; ch_burst[4] = 1;
        step(0, 1, 0, "R9 periph request granted");
        step(1, 4, 0, "R9 periph acts as cycle-steal");
        step(1, 1, 0, "R9 periph alternates");
        ch_req = '0; ch_periph = '0;
        step(1, -1, 0, "R11 all dropped to idle");

        // Peripheral sourcing on upper channels ignored
        ch_req[7] = 1; ch_periph[7] = 1; ch_req[6] = 1; ch_periph[6] = 1;
        step(0, -1, 0, "R10 upper channels ignore periph");
        ch_req[5] = 1; ch_periph[5] = 1;
        step(0, 5, 0, "R10 lower channel accepts periph");
        ch_periph[7] = 0; ch_burst[7] = 1; ch_req[5] = 0; ch_periph[5] = 0;
        step(1, 7, 0, "R10 upper channel normal request");
        ch_req = '0; ch_periph = '0; ch_burst = '0;
        step(1, -1, 0, "R8 idle at end");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule